// File: doc/BRIEF.md
# Four-Slot Group Register Renamer

This block renames up to four instructions per clock. Every slot brings two source register numbers, one destination register number and a freshly allocated physical register. All twelve architectural fields are read from a register map table in parallel. Priority comparators then patch the source and old-destination results wherever an earlier slot of the same group writes that register, so the group behaves as if its slots had been renamed one after another.

The map table lives inside the block. It leaves reset holding the identity mapping: architectural register n maps to physical register n. At each rising clock edge the table takes the new mappings of the group, one per distinct destination, with the latest slot winning. Free-list allocation stays outside: the caller drives one new physical register per slot.

A slot is a *writer* when its valid bit is 1, its has-destination bit is 1 and its destination is not register 0. Only writers forward values to later slots and update the table. Results are produced for every slot, whether or not it is valid.

Top module: `rn_group_rename`

## Requirements
- R1: After reset, looking up architectural register n with no writer in the group returns physical register n.
- R2: Slot 0 source results always equal the table contents for its source registers.
- R3: A source of slot j that equals the destination of exactly one earlier writer in the group returns that writer's new physical register.
- R4: When several earlier writers in the group name the same register as a source of slot j, the result comes from the highest-numbered of them below j.
- R5: Slots that are invalid, have no destination, or target register 0 never change any later slot's source result, which then comes from the table.
- R6: The old-mapping output of slot j is the table entry for its destination register. If an earlier writer in the group targets the same register, the output is instead the new register of the nearest such writer.
- R7: At the clock edge, each register named by at least one writer takes the new physical register of the last such writer in the group. Every other table entry keeps its value.
- R8: A slot's own destination never alters its own source results.
- R9: Architectural register 0 always maps to physical register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, loads identity mapping |
| slot_valid | input | SLOTS | Per-slot valid bit |
| slot_has_dst | input | SLOTS | Per-slot destination-present bit |
| src_a | input | SLOTS*AW | First source register per slot, slot j at bits [j*AW +: AW] |
| src_b | input | SLOTS*AW | Second source register per slot |
| dst_arch | input | SLOTS*AW | Destination register per slot |
| new_preg | input | SLOTS*PW | Allocated physical register per slot |
| phys_a | output | SLOTS*PW | Renamed first source per slot |
| phys_b | output | SLOTS*PW | Renamed second source per slot |
| old_preg | output | SLOTS*PW | Previous mapping of each slot's destination |

## Verification
The hardest situation to reach is a group where three earlier slots all write the register that the last slot reads, with a non-writer mixed in, while the table already holds mappings from previous groups. The bench uses an eight-register configuration. It sweeps all 4096 destination patterns across the four slots. Sources are biased toward the group's own destinations, and valid and destination bits are randomly cleared, so multi-match and suppressed-writer cases occur thousands of times. Periodic full read-backs of the table then confirm the last-writer update.

// File: rtl/rn_pkg.sv
package rn_pkg;

    localparam int DEF_SLOTS     = 4;
    localparam int DEF_ARCH_REGS = 32;
    localparam int DEF_PHYS_REGS = 64;

    // three table lookups are made per slot
    localparam int PORTS_PER_SLOT = 3;

    typedef enum logic [1:0] {
        LK_SRC_A = 2'd0,
        LK_SRC_B = 2'd1,
        LK_DST   = 2'd2
    } lookup_kind_e;

    function automatic int lookup_index(input int slot, input lookup_kind_e kind);
        return slot * PORTS_PER_SLOT + int'(kind);
    endfunction

endpackage

// File: rtl/rn_writer_mask.sv
module rn_writer_mask #(
    parameter int SLOTS = rn_pkg::DEF_SLOTS,
    parameter int AW    = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SLOTS-1:0]     slot_valid,
    input  logic [SLOTS-1:0]     slot_has_dst,
    input  logic [AW-1:0]        dst [SLOTS],
    output logic [SLOTS-1:0]     writer,
    output logic [SLOTS-1:0]     commit
);

    genvar j;
    generate
        for (j = 0; j < SLOTS; j++) begin : g_slot
            logic later_same;

            assign writer[j] = slot_valid[j] && slot_has_dst[j] && (dst[j] != '0);

            // a later writer of the same register supersedes this one
            always_comb begin
                later_same = 1'b0;
                for (int k = j + 1; k < SLOTS; k++) begin
                    if (writer[k] && (dst[k] == dst[j])) later_same = 1'b1;
                end
                commit[j] = writer[j] && !later_same;
            end
        end
    endgenerate

    genvar a, b;
    generate
        for (a = 0; a < SLOTS; a++) begin : g_pair_a
            for (b = a + 1; b < SLOTS; b++) begin : g_pair_b
                assert_unique_commit_R7: assert property (
                    @(posedge clk) disable iff (rst)
                    (commit[a] && commit[b]) |-> (dst[a] != dst[b]));
            end
        end
    endgenerate

endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int ARCH_REGS = rn_pkg::DEF_ARCH_REGS,
    parameter int PHYS_REGS = rn_pkg::DEF_PHYS_REGS,
    parameter int NRD       = 12,
    parameter int NWR       = 4,
    localparam int AW       = $clog2(ARCH_REGS),
    localparam int PW       = $clog2(PHYS_REGS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  rd_addr [NRD],
    output logic [PW-1:0]  rd_data [NRD],
    input  logic [NWR-1:0] wr_en,
    input  logic [AW-1:0]  wr_addr [NWR],
    input  logic [PW-1:0]  wr_data [NWR]
);

    logic [PW-1:0] mem [ARCH_REGS];
    logic [ARCH_REGS*PW-1:0] mem_flat;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ARCH_REGS; r++) mem[r] <= PW'(r);
        end else begin
            for (int w = 0; w < NWR; w++) begin
                if (wr_en[w]) mem[wr_addr[w]] <= wr_data[w];
            end
        end
    end

    genvar p;
    generate
        for (p = 0; p < NRD; p++) begin : g_rd
            assign rd_data[p] = mem[rd_addr[p]];
        end
        for (p = 0; p < ARCH_REGS; p++) begin : g_flat
            assign mem_flat[p*PW +: PW] = mem[p];
        end
    endgenerate

    assert_zero_pinned_R9: assert property (
        @(posedge clk) disable iff (rst)
        mem_flat[PW-1:0] == '0);

    assert_idle_hold_R7: assert property (
        @(posedge clk) disable iff (rst)
        (wr_en == '0) |=> $stable(mem_flat));

endmodule

// File: rtl/rn_dep_check.sv
module rn_dep_check #(
    parameter int SLOTS = rn_pkg::DEF_SLOTS,
    parameter int AW    = 5,
    parameter int PW    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    src_a [SLOTS],
    input  logic [AW-1:0]    src_b [SLOTS],
    input  logic [AW-1:0]    dst   [SLOTS],
    input  logic [SLOTS-1:0] writer,
    input  logic [PW-1:0]    alloc [SLOTS],
    input  logic [PW-1:0]    raw_a [SLOTS],
    input  logic [PW-1:0]    raw_b [SLOTS],
    input  logic [PW-1:0]    raw_d [SLOTS],
    output logic [PW-1:0]    fix_a [SLOTS],
    output logic [PW-1:0]    fix_b [SLOTS],
    output logic [PW-1:0]    fix_d [SLOTS]
);

    genvar j;
    generate
        for (j = 0; j < SLOTS; j++) begin : g_slot
            // ascending scan: the last hit is the nearest earlier writer
            always_comb begin
                fix_a[j] = raw_a[j];
                fix_b[j] = raw_b[j];
                fix_d[j] = raw_d[j];
                for (int i = 0; i < j; i++) begin
                    if (writer[i]) begin
                        if (dst[i] == src_a[j]) fix_a[j] = alloc[i];
                        if (dst[i] == src_b[j]) fix_b[j] = alloc[i];
                        if (dst[i] == dst[j])   fix_d[j] = alloc[i];
                    end
                end
            end

            if (j > 0) begin : g_chk
                assert_nearest_a_R4: assert property (
                    @(posedge clk) disable iff (rst)
                    (writer[j-1] && dst[j-1] == src_a[j]) |-> fix_a[j] == alloc[j-1]);
                assert_nearest_b_R4: assert property (
                    @(posedge clk) disable iff (rst)
                    (writer[j-1] && dst[j-1] == src_b[j]) |-> fix_b[j] == alloc[j-1]);
                assert_old_fwd_R6: assert property (
                    @(posedge clk) disable iff (rst)
                    (writer[j-1] && dst[j-1] == dst[j]) |-> fix_d[j] == alloc[j-1]);
                assert_table_path_R5: assert property (
                    @(posedge clk) disable iff (rst)
                    (writer[j-1:0] == '0) |-> (fix_a[j] == raw_a[j] && fix_b[j] == raw_b[j]));
            end
        end
    endgenerate

endmodule

// File: rtl/rn_group_rename.sv
module rn_group_rename #(
    parameter int SLOTS     = rn_pkg::DEF_SLOTS,
    parameter int ARCH_REGS = rn_pkg::DEF_ARCH_REGS,
    parameter int PHYS_REGS = rn_pkg::DEF_PHYS_REGS,
    localparam int AW       = $clog2(ARCH_REGS),
    localparam int PW       = $clog2(PHYS_REGS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SLOTS-1:0]    slot_valid,
    input  logic [SLOTS-1:0]    slot_has_dst,
    input  logic [SLOTS*AW-1:0] src_a,
    input  logic [SLOTS*AW-1:0] src_b,
    input  logic [SLOTS*AW-1:0] dst_arch,
    input  logic [SLOTS*PW-1:0] new_preg,
    output logic [SLOTS*PW-1:0] phys_a,
    output logic [SLOTS*PW-1:0] phys_b,
    output logic [SLOTS*PW-1:0] old_preg
);
    import rn_pkg::*;

    localparam int NRD = SLOTS * PORTS_PER_SLOT;

    logic [AW-1:0]    sa [SLOTS];
    logic [AW-1:0]    sb [SLOTS];
    logic [AW-1:0]    sd [SLOTS];
    logic [PW-1:0]    al [SLOTS];
    logic [AW-1:0]    lk_addr [NRD];
    logic [PW-1:0]    lk_data [NRD];
    logic [PW-1:0]    raw_a [SLOTS];
    logic [PW-1:0]    raw_b [SLOTS];
    logic [PW-1:0]    raw_d [SLOTS];
    logic [PW-1:0]    fix_a [SLOTS];
    logic [PW-1:0]    fix_b [SLOTS];
    logic [PW-1:0]    fix_d [SLOTS];
    logic [SLOTS-1:0] writer;
    logic [SLOTS-1:0] commit;

    genvar j;
    generate
        for (j = 0; j < SLOTS; j++) begin : g_slot
            assign sa[j] = src_a[j*AW +: AW];
            assign sb[j] = src_b[j*AW +: AW];
            assign sd[j] = dst_arch[j*AW +: AW];
            assign al[j] = new_preg[j*PW +: PW];

            assign lk_addr[lookup_index(j, LK_SRC_A)] = sa[j];
            assign lk_addr[lookup_index(j, LK_SRC_B)] = sb[j];
            assign lk_addr[lookup_index(j, LK_DST)]   = sd[j];

            assign raw_a[j] = lk_data[lookup_index(j, LK_SRC_A)];
            assign raw_b[j] = lk_data[lookup_index(j, LK_SRC_B)];
            assign raw_d[j] = lk_data[lookup_index(j, LK_DST)];

            assign phys_a[j*PW +: PW]   = fix_a[j];
            assign phys_b[j*PW +: PW]   = fix_b[j];
            assign old_preg[j*PW +: PW] = fix_d[j];
        end
    endgenerate

    rn_writer_mask #(.SLOTS(SLOTS), .AW(AW)) u_mask (
        .clk         (clk),
        .rst         (rst),
        .slot_valid  (slot_valid),
        .slot_has_dst(slot_has_dst),
        .dst         (sd),
        .writer      (writer),
        .commit      (commit)
    );

    rn_map_table #(
        .ARCH_REGS(ARCH_REGS),
        .PHYS_REGS(PHYS_REGS),
        .NRD      (NRD),
        .NWR      (SLOTS)
    ) u_table (
        .clk    (clk),
        .rst    (rst),
        .rd_addr(lk_addr),
        .rd_data(lk_data),
        .wr_en  (commit),
        .wr_addr(sd),
        .wr_data(al)
    );

    rn_dep_check #(.SLOTS(SLOTS), .AW(AW), .PW(PW)) u_dep (
        .clk   (clk),
        .rst   (rst),
        .src_a (sa),
        .src_b (sb),
        .dst   (sd),
        .writer(writer),
        .alloc (al),
        .raw_a (raw_a),
        .raw_b (raw_b),
        .raw_d (raw_d),
        .fix_a (fix_a),
        .fix_b (fix_b),
        .fix_d (fix_d)
    );

endmodule

// File: tb/rn_group_rename_test.sv
module rn_group_rename_test;
    localparam int S  = 4;
    localparam int AR = 8;
    localparam int PR = 32;
    localparam int AW = 3;
    localparam int PW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [S-1:0]    slot_valid = '0;
    logic [S-1:0]    slot_has_dst = '0;
    logic [S*AW-1:0] src_a = '0, src_b = '0, dst_arch = '0;
    logic [S*PW-1:0] new_preg = '0;
    logic [S*PW-1:0] phys_a, phys_b, old_preg;

    int checks = 0;
    int fails  = 0;
    int model [AR];
    int g_sa [S], g_sb [S], g_d [S], g_al [S];
    logic [S-1:0] g_va, g_hd;
    string force_tag = "";

    always #4 clk = ~clk;

    rn_group_rename #(.SLOTS(S), .ARCH_REGS(AR), .PHYS_REGS(PR)) uut (
        .clk(clk), .rst(rst), .slot_valid(slot_valid), .slot_has_dst(slot_has_dst),
        .src_a(src_a), .src_b(src_b), .dst_arch(dst_arch), .new_preg(new_preg),
        .phys_a(phys_a), .phys_b(phys_b), .old_preg(old_preg));

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic bit is_writer(input int i);
        return g_va[i] && g_hd[i] && (g_d[i] != 0);
    endfunction

    function automatic string src_tag(input int j, input int hits, input int src);
        if (force_tag != "") return force_tag;
        if (j == 0) return "R2";
        if (hits > 1) return "R4";
        if (hits == 1) return "R3";
        if (is_writer(j) && g_d[j] == src) return "R8";
        return "R5";
    endfunction

    task automatic apply_group();
        for (int j = 0; j < S; j++) begin
            src_a[j*AW +: AW]    = AW'(g_sa[j]);
            src_b[j*AW +: AW]    = AW'(g_sb[j]);
            dst_arch[j*AW +: AW] = AW'(g_d[j]);
            new_preg[j*PW +: PW] = PW'(g_al[j]);
        end
        slot_valid   = g_va;
        slot_has_dst = g_hd;
        #1;
        for (int j = 0; j < S; j++) begin
            int ea = model[g_sa[j]], eb = model[g_sb[j]], eo = model[g_d[j]];
            int ha = 0, hb = 0;
            for (int i = 0; i < j; i++) begin
                if (is_writer(i)) begin
                    if (g_d[i] == g_sa[j]) begin ea = g_al[i]; ha++; end
                    if (g_d[i] == g_sb[j]) begin eb = g_al[i]; hb++; end
                    if (g_d[i] == g_d[j])  eo = g_al[i];
                end
            end
            check(src_tag(j, ha, g_sa[j]), int'(phys_a[j*PW +: PW]), ea);
            check(src_tag(j, hb, g_sb[j]), int'(phys_b[j*PW +: PW]), eb);
            check(force_tag != "" ? force_tag : "R6", int'(old_preg[j*PW +: PW]), eo);
        end
        // R7: last writer of each register lands in the table
        for (int j = 0; j < S; j++) if (is_writer(j)) model[g_d[j]] = g_al[j];
        @(negedge clk);
    endtask

    task automatic readback(input string tag);
        force_tag = tag;
        for (int half = 0; half < 2; half++) begin
            g_va = '0; g_hd = '0;
            for (int j = 0; j < S; j++) begin
                g_sa[j] = half * 4 + j;
                g_sb[j] = (half * 4 + j + 3) % AR;
                g_d[j]  = j;
                g_al[j] = 0;
            end
            apply_group();
        end
        force_tag = "";
    endtask

    task automatic random_group(input int p, input bit sweep);
        for (int j = 0; j < S; j++) begin
            g_d[j]  = sweep ? ((p >> (3 * j)) & 7) : int'($urandom % AR);
            g_al[j] = int'($urandom % PR);
        end
        g_va = ($urandom % 4 == 0) ? S'($urandom) : '1;
        g_hd = ($urandom % 4 == 0) ? S'($urandom) : '1;
        for (int j = 0; j < S; j++) begin
            g_sa[j] = ($urandom % 3 != 0) ? g_d[$urandom % S] : int'($urandom % AR);
            g_sb[j] = ($urandom % 3 != 0) ? g_d[$urandom % S] : int'($urandom % AR);
        end
        apply_group();
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < AR; r++) model[r] = r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        readback("R1");

        // R4: three earlier writers of register 5, slot 3 reads it
        g_va = '1; g_hd = '1;
        g_d  = '{5, 5, 5, 6};
        g_al = '{10, 11, 12, 13};
        g_sa = '{5, 5, 5, 5};
        g_sb = '{1, 5, 6, 6};
        apply_group();
        // R5: non-writers (no dst, invalid, register 0) do not forward
        g_va = 4'b1101; g_hd = 4'b1110;
        g_d  = '{3, 3, 0, 2};
        g_al = '{20, 21, 22, 23};
        g_sa = '{3, 3, 0, 3};
        g_sb = '{2, 0, 3, 0};
        apply_group();
        readback("R7");

        for (int p = 0; p < 4096; p++) begin
            random_group(p, 1'b1);
            if (p % 256 == 255) readback("R7");
        end
        for (int n = 0; n < 1500; n++) random_group(n, 1'b0);
        readback("R7");

        force_tag = "R9";
        g_va = '0; g_hd = '0;
        g_sa = '{0, 0, 0, 0}; g_sb = '{0, 0, 0, 0}; g_d = '{0, 0, 0, 0};
        g_al = '{0, 0, 0, 0};
        apply_group();
        force_tag = "";

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule